// File: doc/BRIEF.md
# Region-Restricted Column Pointer for a Paged Read Register

This block keeps the byte column of a 528-byte page register. A page is split into three windows: a lower main half (columns 0 to 255), an upper main half (256 to 511) and a 16-byte spare area (512 to 527). A read command picks the window. The first address byte then gives the start offset inside that window, and the next two bytes give a 14-bit page number. Once the page fetch is done, every read-enable falling-edge strobe moves the pointer forward by one column. Array storage sits outside this block. The block only drives the column index, the page number, a fetch request, a page-increment pulse, a busy flag and a select that chooses between data output and status output.

When the pointer is on the last column and a further strobe arrives, the block waits for chip enable to settle. If chip enable stays low for a set number of cycles, the block starts a fetch of the next page and restarts the column at the start of the window. If chip enable stays high for that many cycles, the sequential read ends. On the highest page the pointer stays on column 527. A status command swaps the output to status, and a later lower-half read command swaps it back without moving the column. All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `cp_column_pointer`

## Requirements
- R1: Command 0x00 followed by a first address byte B sets the column to B. Command 0x01 followed by B sets it to 256+B, so bit 8 comes from the command.
- R2: Command 0x50 followed by a first address byte B sets the column to 512 + B[3:0]. Bits 7:4 of B have no effect.
- R3: After 0x50, the spare window stays selected. A later 0x01 still places the column at 512 + B[3:0]. Only 0x00 or 0xFF leaves the spare window.
- R4: Address bytes arrive in a fixed order: column offset, page bits 7:0, then page bits 13:8 (from B[5:0]). The third byte gives a one-cycle fetch_req and raises busy. Busy stays high until fetch_done.
- R5: In read mode, while not busy and not in status output, each re_fall strobe adds one to the column, up to 527.
- R6: A re_fall strobe while busy leaves the column unchanged.
- R7: A strobe at column 527 on a page below 0x3FFF, followed by ce_n low for CE_HOLD_CYC cycles, gives page_inc and fetch_req together. The page rises by one and busy goes high. On fetch_done the column restarts at 0 (windows 0x00/0x01) or at 512 (spare window).
- R8: On page 0x3FFF, strobes at column 527 keep the column at 527. They give no fetch and no busy.
- R9: ce_n high for CE_HOLD_CYC consecutive cycles after a strobe at column 527 ends the read with no fetch.
- R10: Command 0x70 sets sel_status. Strobes then leave the column unchanged. A following 0x00 clears sel_status and keeps the column, with no address needed.
- R11: Reset, or command 0xFF at any time, clears the column, the page, busy and sel_status, selects the lower window and leaves read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte |
| addr_valid | input | 1 | Address byte strobe |
| addr_byte | input | 8 | Address byte |
| re_fall | input | 1 | One-cycle pulse per read-enable falling edge |
| ce_n | input | 1 | Chip enable, active low |
| fetch_done | input | 1 | Page fetch completed |
| col_idx | output | 10 | Current column, 0 to 527 |
| page_addr | output | 14 | Current page number |
| page_inc | output | 1 | Pulse when the page number steps |
| fetch_req | output | 1 | Pulse requesting a page fetch |
| busy | output | 1 | Fetch in progress |
| sel_status | output | 1 | 1 selects status output, 0 selects data |

## Verification
Strobes, commands and address bytes act on the next rising edge. The column, sel_status, busy and the fetch_req pulse are therefore due one cycle after the input, and the bench samples at the falling edge that follows that rising edge. At column 527 the fetch or the end of the read comes CE_HOLD_CYC cycles after the strobe. The bench waits CE_HOLD_CYC+2 cycles before it compares page, busy and the fetch count. Fetch pulses are counted by a monitor at each rising edge, so the bench compares counts only after idle cycles.

// File: rtl/cp_pkg.sv
package cp_pkg;
  localparam int MAIN_BYTES  = 512;
  localparam int SPARE_BYTES = 16;
  localparam int HALF_BYTES  = MAIN_BYTES / 2;
  localparam int PAGE_BYTES  = MAIN_BYTES + SPARE_BYTES;
  localparam int COL_W       = $clog2(PAGE_BYTES);
  localparam int LAST_COL    = PAGE_BYTES - 1;
  localparam int SPARE_W     = $clog2(SPARE_BYTES);

  localparam logic [7:0] CMD_RD_LOW   = 8'h00;
  localparam logic [7:0] CMD_RD_HIGH  = 8'h01;
  localparam logic [7:0] CMD_RD_SPARE = 8'h50;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_RESET    = 8'hFF;

  typedef enum logic [1:0] {WIN_LOW, WIN_HIGH, WIN_SPARE} win_t;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_END, ST_FETCH} cp_state_t;
endpackage

// File: rtl/cp_start_calc.sv
module cp_start_calc
  import cp_pkg::*;
(
  input  win_t               win,
  input  logic [7:0]         addr_byte,
  output logic [COL_W-1:0]   start_col,
  output logic [COL_W-1:0]   wrap_col
);
  always_comb begin
    unique case (win)
      WIN_HIGH:  start_col = COL_W'(HALF_BYTES) + COL_W'(addr_byte);
      WIN_SPARE: start_col = COL_W'(MAIN_BYTES) + COL_W'(addr_byte[SPARE_W-1:0]);
      default:   start_col = COL_W'(addr_byte);
    endcase
    wrap_col = (win == WIN_SPARE) ? COL_W'(MAIN_BYTES) : '0;
  end
endmodule

// File: rtl/cp_end_detect.sv
module cp_end_detect #(
  parameter int CE_HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic ce_n,
  output logic go_fetch,
  output logic go_stop
);
  localparam int CNT_W = $clog2(CE_HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(CE_HOLD_CYC - 1);

  logic [CNT_W-1:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else if (!arm) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else if (ce_n) begin
      lo_cnt <= '0;
      if (hi_cnt != HOLD_LAST) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
      if (lo_cnt != HOLD_LAST) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  assign go_stop  = arm &&  ce_n && (hi_cnt == HOLD_LAST);
  assign go_fetch = arm && !ce_n && (lo_cnt == HOLD_LAST);
endmodule

// File: rtl/cp_column_pointer.sv
module cp_column_pointer
  import cp_pkg::*;
#(
  parameter int PAGE_W      = 14,
  parameter int CE_HOLD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic              addr_valid,
  input  logic [7:0]        addr_byte,
  input  logic              re_fall,
  input  logic              ce_n,
  input  logic              fetch_done,
  output logic [COL_W-1:0]  col_idx,
  output logic [PAGE_W-1:0] page_addr,
  output logic              page_inc,
  output logic              fetch_req,
  output logic              busy,
  output logic              sel_status
);
  localparam logic [1:0]        ADDR_DONE = 2'd3;
  localparam logic [COL_W-1:0]  COL_END   = COL_W'(LAST_COL);
  localparam logic [PAGE_W-1:0] PAGE_TOP  = '1;

  cp_state_t        state;
  win_t             win;
  logic [1:0]       addr_cnt;
  logic             wrap_pend;
  logic [COL_W-1:0] start_col, wrap_col;
  logic             go_fetch, go_stop;
  logic             is_reset_cmd;

  assign is_reset_cmd = cmd_valid && (cmd_code == CMD_RESET);
  assign busy = (state == ST_FETCH);

  cp_start_calc u_start (
    .win       (win),
    .addr_byte (addr_byte),
    .start_col (start_col),
    .wrap_col  (wrap_col)
  );

  cp_end_detect #(.CE_HOLD_CYC(CE_HOLD_CYC)) u_end (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (state == ST_END && !cmd_valid),
    .ce_n     (ce_n),
    .go_fetch (go_fetch),
    .go_stop  (go_stop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      win        <= WIN_LOW;
      addr_cnt   <= ADDR_DONE;
      wrap_pend  <= 1'b0;
      col_idx    <= '0;
      page_addr  <= '0;
      page_inc   <= 1'b0;
      fetch_req  <= 1'b0;
      sel_status <= 1'b0;
    end else begin
      page_inc  <= 1'b0;
      fetch_req <= 1'b0;
      if (is_reset_cmd) begin
        state      <= ST_IDLE;
        win        <= WIN_LOW;
        addr_cnt   <= ADDR_DONE;
        wrap_pend  <= 1'b0;
        col_idx    <= '0;
        page_addr  <= '0;
        sel_status <= 1'b0;
      end else if (cmd_valid) begin
        if (cmd_code == CMD_STATUS) begin
          sel_status <= 1'b1;
        end else if (state != ST_FETCH) begin
          unique case (cmd_code)
            CMD_RD_LOW: begin
              win        <= WIN_LOW;
              state      <= ST_READ;
              sel_status <= 1'b0;
              addr_cnt   <= sel_status ? ADDR_DONE : 2'd0;
            end
            CMD_RD_HIGH: begin
              win        <= (win == WIN_SPARE) ? WIN_SPARE : WIN_HIGH;
              state      <= ST_READ;
              sel_status <= 1'b0;
              addr_cnt   <= 2'd0;
            end
            CMD_RD_SPARE: begin
              win        <= WIN_SPARE;
              state      <= ST_READ;
              sel_status <= 1'b0;
              addr_cnt   <= 2'd0;
            end
            default: ;
          endcase
        end
      end else if (state == ST_FETCH) begin
        if (fetch_done) begin
          state <= ST_READ;
          if (wrap_pend) col_idx <= wrap_col;
          wrap_pend <= 1'b0;
        end
      end else if (state == ST_END) begin
        if (go_fetch) begin
          state     <= ST_FETCH;
          wrap_pend <= 1'b1;
          page_addr <= page_addr + 1'b1;
          page_inc  <= 1'b1;
          fetch_req <= 1'b1;
        end else if (go_stop) begin
          state <= ST_IDLE;
        end
      end else if (state == ST_READ && addr_valid && addr_cnt != ADDR_DONE) begin
        addr_cnt <= addr_cnt + 1'b1;
        unique case (addr_cnt)
          2'd0: col_idx <= start_col;
          2'd1: page_addr[7:0] <= addr_byte;
          default: begin
            page_addr[PAGE_W-1:8] <= addr_byte[PAGE_W-9:0];
            state     <= ST_FETCH;
            wrap_pend <= 1'b0;
            fetch_req <= 1'b1;
          end
        endcase
      end else if (state == ST_READ && re_fall && !sel_status) begin
        if (col_idx != COL_END) col_idx <= col_idx + 1'b1;
        else if (page_addr != PAGE_TOP) state <= ST_END;
      end
    end
  end

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fetch_done && !is_reset_cmd |=> $stable(col_idx));
  // R7
  inc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_inc |-> fetch_req && busy);
  // R7
  page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_inc |-> page_addr == $past(page_addr) + 1'b1);
  // R10
  status_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_status && re_fall && !cmd_valid && !addr_valid |=> $stable(col_idx));
  // R5
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_idx <= COL_END);
  // R8
  top_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_addr == PAGE_TOP && !busy && !cmd_valid && !addr_valid |=> !fetch_req);
endmodule

// File: tb/cp_column_pointer_bench.sv
module cp_column_pointer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, addr_valid = 0, re_fall = 0, ce_n = 0, fetch_done = 0;
  logic [7:0] cmd_code = 0, addr_byte = 0;
  logic [9:0] col_idx;
  logic [13:0] page_addr;
  logic page_inc, fetch_req, busy, sel_status;
  int errors = 0, checks = 0, n_fetch = 0, n_inc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cp_column_pointer #(.PAGE_W(14), .CE_HOLD_CYC(HOLD)) u_cp_column_pointer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .addr_valid(addr_valid), .addr_byte(addr_byte), .re_fall(re_fall),
    .ce_n(ce_n), .fetch_done(fetch_done), .col_idx(col_idx),
    .page_addr(page_addr), .page_inc(page_inc), .fetch_req(fetch_req),
    .busy(busy), .sel_status(sel_status));

  always @(posedge clk) begin
    if (fetch_req) n_fetch++;
    if (page_inc) n_inc++;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    @(negedge clk); cmd_valid = 1; cmd_code = c;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic send_addr(input logic [7:0] b);
    @(negedge clk); addr_valid = 1; addr_byte = b;
    @(negedge clk); addr_valid = 0;
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); re_fall = 1;
      @(negedge clk); re_fall = 0;
    end
  endtask

  task automatic finish_fetch();
    @(negedge clk); fetch_done = 1;
    @(negedge clk); fetch_done = 0;
  endtask

  task automatic setup_read(input logic [7:0] c, input logic [7:0] col,
                            input logic [13:0] pg, input string tag);
    send_cmd(c);
    send_addr(col);
    send_addr(pg[7:0]);
    send_addr({2'b00, pg[13:8]});
    check({tag, " R4 fetch_req"}, int'(fetch_req), 1);
    check({tag, " R4 busy"}, int'(busy), 1);
    finish_fetch();
    check({tag, " R4 busy clear"}, int'(busy), 0);
  endtask

  task automatic t_reset();
    check("R11 reset col", int'(col_idx), 0);
    check("R11 reset busy", int'(busy), 0);
    check("R11 reset status", int'(sel_status), 0);
    check("R11 reset page", int'(page_addr), 0);
  endtask

  task automatic t_low_and_busy();
    send_cmd(8'h00);
    send_addr(8'h10);
    send_addr(8'h05);
    send_addr(8'h00);
    strobe(2);
    check("R6 strobe while busy", int'(col_idx), 16);
    finish_fetch();
    check("R1 low start", int'(col_idx), 16);
    check("R4 page", int'(page_addr), 5);
    strobe(3);
    check("R5 increment", int'(col_idx), 19);
  endtask

  task automatic t_high();
    setup_read(8'h01, 8'h05, 14'd9, "high");
    check("R1 high start", int'(col_idx), 261);
  endtask

  task automatic t_spare_sticky();
    setup_read(8'h50, 8'hF3, 14'd3, "spare");
    check("R2 spare start ignores upper bits", int'(col_idx), 515);
    setup_read(8'h01, 8'h02, 14'd3, "sticky");
    check("R3 spare stays after 0x01", int'(col_idx), 514);
    setup_read(8'h00, 8'h02, 14'd3, "leave");
    check("R3 0x00 leaves spare", int'(col_idx), 2);
  endtask

  task automatic t_wrap_high();
    int f0, i0;
    setup_read(8'h01, 8'hFF, 14'd7, "wrapB");
    strobe(16);
    check("R5 reach end", int'(col_idx), 527);
    f0 = n_fetch; i0 = n_inc;
    strobe(1);
    idle(HOLD + 2);
    check("R7 fetch count", n_fetch - f0, 1);
    check("R7 inc count", n_inc - i0, 1);
    check("R7 page step", int'(page_addr), 8);
    check("R7 busy", int'(busy), 1);
    finish_fetch();
    check("R7 restart col 0", int'(col_idx), 0);
  endtask

  task automatic t_wrap_spare();
    setup_read(8'h50, 8'h0F, 14'd20, "wrapC");
    check("R2 spare end start", int'(col_idx), 527);
    strobe(1);
    idle(HOLD + 2);
    check("R7 spare page step", int'(page_addr), 21);
    finish_fetch();
    check("R7 restart col 512", int'(col_idx), 512);
  endtask

  task automatic t_last_page();
    int f0;
    setup_read(8'h50, 8'h0F, 14'h3FFF, "last");
    f0 = n_fetch;
    strobe(3);
    idle(HOLD + 2);
    check("R8 park col", int'(col_idx), 527);
    check("R8 no busy", int'(busy), 0);
    check("R8 no fetch", n_fetch - f0, 0);
  endtask

  task automatic t_ce_stop();
    int f0;
    setup_read(8'h50, 8'h0F, 14'd40, "stop");
    f0 = n_fetch;
    @(negedge clk); re_fall = 1;
    @(negedge clk); re_fall = 0; ce_n = 1;
    idle(HOLD + 2);
    ce_n = 0;
    idle(HOLD + 2);
    check("R9 no fetch", n_fetch - f0, 0);
    check("R9 page kept", int'(page_addr), 40);
    check("R9 not busy", int'(busy), 0);
  endtask

  task automatic t_status();
    setup_read(8'h00, 8'h14, 14'd2, "status");
    strobe(2);
    send_cmd(8'h70);
    check("R10 status on", int'(sel_status), 1);
    strobe(2);
    check("R10 col frozen", int'(col_idx), 22);
    send_cmd(8'h00);
    check("R10 status off", int'(sel_status), 0);
    check("R10 col kept", int'(col_idx), 22);
    strobe(1);
    check("R10 resume", int'(col_idx), 23);
  endtask

  task automatic t_ff();
    setup_read(8'h50, 8'h03, 14'd11, "ff");
    send_cmd(8'hFF);
    check("R11 ff col", int'(col_idx), 0);
    check("R11 ff page", int'(page_addr), 0);
    setup_read(8'h01, 8'h01, 14'd1, "afterff");
    check("R11 window back to normal", int'(col_idx), 257);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset();
    t_low_and_busy();
    t_high();
    t_spare_sticky();
    t_wrap_high();
    t_wrap_spare();
    t_last_page();
    t_ce_stop();
    t_status();
    t_ff();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule